// File: doc/BRIEF.md
# Periodic Memory Integrity Monitor

This block guards two kinds of on-chip storage against silent corruption. On a slow period it walks a bank of non-volatile configuration words through an external read port, adds them into a 16-bit running sum, and compares the total with a stored reference word. Two configurable addresses are skipped during that walk. A mismatch produces a one-cycle pulse on `nvm_fault`.

Independently, straight after reset the block writes a fixed constant into an external volatile register. On a fast period it then compares that register with the same constant for as long as the chip runs. Any difference produces a one-cycle pulse on `por_fault`. The register is never rewritten while the chip is running. Only a new reset restores it.

Both fault pulses are meant to set sticky bits in a status register that lives outside the block. Both periods are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter.

Top module: `mem_integrity_mon`

## Requirements
- R1: While reset is low, `nvm_fault` and `por_fault` are 0, `vol_we` is 1 and `vol_wdata` equals `ROM_VAL`.
- R2: Clock edges are numbered from 1, with edge 1 being the first edge after reset is released. `vol_we` is 1 only before edge 1, so the volatile register is written once, at edge 1. It then stays 0 until the next reset.
- R3: Let P = `POR_PERIOD_US` × `CYC_PER_US`. The volatile compare uses `vol_rdata` in the cycle before edge kP+1 (k ≥ 1). Its result is visible on `por_fault` right after edge kP+1. At every other edge `por_fault` is 0.
- R4: `por_fault` pulses after edge kP+1 exactly when `vol_rdata` differed from `ROM_VAL` during the compare cycle.
- R5: A corrupted volatile register is never repaired by the block, so `por_fault` pulses again at every later compare.
- R6: Let N = `NVM_PERIOD_US` × `CYC_PER_US`. Scan k (k ≥ 1) presents address i on `nvm_addr` in the cycle after edge kN+1+i, for i = 0 to `WORDS`−1 in ascending order.
- R7: The checksum is the sum modulo 2^16 of every 16-bit word read during a scan, except the words at addresses `EXCL_A` and `EXCL_B` (3 and 9 by default). If the sum equals `nvm_ref`, no pulse is raised.
- R8: If the checksum differs from `nvm_ref`, `nvm_fault` is 1 right after edge kN+`WORDS`+1.
- R9: The contents of the two excluded addresses have no effect on `nvm_fault`.
- R10: Each fault output is high for at most one cycle at a time and is 0 outside its result cycles.
- R11: A new reset rewrites the volatile register with `ROM_VAL`, which ends the repeated `por_fault` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| nvm_addr | output | AW = clog2(WORDS) | Word address of the non-volatile bank being read |
| nvm_rdata | input | 16 | Word at `nvm_addr` (combinational read) |
| nvm_ref | input | 16 | Stored reference checksum |
| vol_we | output | 1 | Write strobe for the volatile register |
| vol_wdata | output | 16 | Constant written into the volatile register |
| vol_rdata | input | 16 | Current contents of the volatile register |
| nvm_fault | output | 1 | One-cycle pulse: checksum mismatch |
| por_fault | output | 1 | One-cycle pulse: volatile register differs from the constant |

## Verification
The checksum path is tried with five bank patterns:
- A matching bank tests for false alarms.
- A single flipped bit in a counted word shows that a real change is detected.
- Rewriting only the two excluded words, with the reference unchanged, shows those words are truly left out.
- An all-ones bank whose sum wraps past 16 bits confirms the modular arithmetic.
- A reference off by one separates a correct sum from one that compares badly.

The volatile path is watched at every compare point:
- With an intact register, no pulse appears.
- A one-shot bit flip must then give a pulse at every later compare.
- A final reset must clear those pulses, which shows the reload happens only at reset.

// File: rtl/mim_pkg.sv
package mim_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic word_t csum_add(input word_t acc, input word_t w);
        return acc + w;
    endfunction

endpackage

// File: rtl/mim_timer.sv
module mim_timer #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = en && (tmr_q.cnt == CW'(LIMIT - 1));
        if (en) begin
            tmr_d.cnt = tick ? '0 : tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/mim_nvm_scan.sv
module mim_nvm_scan
    import mim_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int AW     = 4,
    parameter int EXCL_A = 3,
    parameter int EXCL_B = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  word_t         rdata,
    input  word_t         ref_sum,
    output logic [AW-1:0] addr,
    output logic          busy,
    output logic          last,
    output logic          fault
);
    typedef struct packed {
        logic          busy;
        logic [AW-1:0] addr;
        word_t         acc;
        logic          fault;
    } scan_t;

    scan_t scan_d, scan_q;
    word_t sum_nx;
    logic  skip;

    always_comb begin
        scan_d       = scan_q;
        scan_d.fault = 1'b0;
        skip   = (scan_q.addr == AW'(EXCL_A)) || (scan_q.addr == AW'(EXCL_B));
        sum_nx = skip ? scan_q.acc : csum_add(scan_q.acc, rdata);
        last   = scan_q.busy && (scan_q.addr == AW'(WORDS - 1));
        if (scan_q.busy) begin
            scan_d.acc  = sum_nx;
            scan_d.addr = scan_q.addr + 1'b1;
            if (last) begin
                scan_d.busy  = 1'b0;
                scan_d.fault = (sum_nx != ref_sum);
            end
        end else if (start) begin
            scan_d.busy = 1'b1;
            scan_d.addr = '0;
            scan_d.acc  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign addr  = scan_q.addr;
    assign busy  = scan_q.busy;
    assign fault = scan_q.fault;
endmodule

// File: rtl/mim_por_check.sv
module mim_por_check
    import mim_pkg::*;
#(
    parameter word_t ROM_VAL = 16'hA5C3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  word_t vol_rdata,
    output logic  vol_we,
    output word_t vol_wdata,
    output logic  running,
    output logic  fault
);
    typedef struct packed {
        phase_e ph;
        logic   fault;
    } por_t;

    por_t por_d, por_q;

    always_comb begin
        por_d       = por_q;
        por_d.fault = 1'b0;
        if (por_q.ph == PH_LOAD) begin
            por_d.ph = PH_RUN;
        end else if (tick && (vol_rdata != ROM_VAL)) begin
            por_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) por_q <= '{ph: PH_LOAD, fault: 1'b0};
        else        por_q <= por_d;
    end

    assign vol_we    = (por_q.ph == PH_LOAD);
    assign vol_wdata = ROM_VAL;
    assign running   = (por_q.ph == PH_RUN);
    assign fault     = por_q.fault;
endmodule

// File: rtl/mem_integrity_mon.sv
module mem_integrity_mon
    import mim_pkg::*;
#(
    parameter int    WORDS         = 16,
    parameter int    CYC_PER_US    = 50,
    parameter int    NVM_PERIOD_US = 50,
    parameter int    POR_PERIOD_US = 1,
    parameter int    EXCL_A        = 3,
    parameter int    EXCL_B        = 9,
    parameter word_t ROM_VAL       = 16'hA5C3,
    localparam int   AW            = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] nvm_addr,
    input  logic [15:0]   nvm_rdata,
    input  logic [15:0]   nvm_ref,
    output logic          vol_we,
    output logic [15:0]   vol_wdata,
    input  logic [15:0]   vol_rdata,
    output logic          nvm_fault,
    output logic          por_fault
);
    localparam int NVM_CYC = NVM_PERIOD_US * CYC_PER_US;
    localparam int POR_CYC = POR_PERIOD_US * CYC_PER_US;

    logic running;
    logic por_tick;
    logic nvm_tick;
    logic scan_busy;
    logic scan_last;

    mim_por_check #(.ROM_VAL(ROM_VAL)) u_por (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (por_tick),
        .vol_rdata (vol_rdata),
        .vol_we    (vol_we),
        .vol_wdata (vol_wdata),
        .running   (running),
        .fault     (por_fault)
    );

    mim_timer #(.LIMIT(POR_CYC)) u_por_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .tick  (por_tick)
    );

    mim_timer #(.LIMIT(NVM_CYC)) u_nvm_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .tick  (nvm_tick)
    );

    mim_nvm_scan #(
        .WORDS  (WORDS),
        .AW     (AW),
        .EXCL_A (EXCL_A),
        .EXCL_B (EXCL_B)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (nvm_tick),
        .rdata   (nvm_rdata),
        .ref_sum (nvm_ref),
        .addr    (nvm_addr),
        .busy    (scan_busy),
        .last    (scan_last),
        .fault   (nvm_fault)
    );
endmodule

// File: rtl/mim_check.sv
module mim_check (
    input logic clk,
    input logic rst_n,
    input logic vol_we,
    input logic nvm_fault,
    input logic por_fault,
    input logic por_tick,
    input logic nvm_tick,
    input logic scan_busy,
    input logic scan_last
);
    // R2: the startup write is a single cycle
    a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        vol_we |=> !vol_we);

    // R2: once the write has ended it never comes back while running
    a_r2_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        !vol_we |=> !vol_we);

    // R10: each fault is a single-cycle pulse
    a_r10_nvm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_fault |=> !nvm_fault);

    a_r10_por_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        por_fault |=> !por_fault);

    // R3: a volatile fault follows a compare tick
    a_r3_por_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        por_fault |-> $past(por_tick));

    // R8: a checksum fault follows the last word of a scan
    a_r8_nvm_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_fault |-> $past(scan_last));

    // R6: a new scan never starts while one is still running
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_tick |-> !scan_busy);
endmodule

bind mem_integrity_mon mim_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vol_we    (vol_we),
    .nvm_fault (nvm_fault),
    .por_fault (por_fault),
    .por_tick  (por_tick),
    .nvm_tick  (nvm_tick),
    .scan_busy (scan_busy),
    .scan_last (scan_last)
);

// File: tb/mem_integrity_mon_test.sv
module mem_integrity_mon_test;
    localparam int          WORDS = 16;
    localparam int          CPU   = 4;
    localparam int          N     = 50 * CPU;
    localparam int          P     = 1 * CPU;
    localparam int          EXA   = 3;
    localparam int          EXB   = 9;
    localparam logic [15:0] ROM   = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  nvm_addr;
    logic [15:0] nvm_mem [WORDS];
    logic [15:0] nvm_rdata, nvm_ref;
    logic        vol_we;
    logic [15:0] vol_wdata, vol_rdata, vol_reg, hit_mask;
    logic        hit;
    logic        nvm_fault, por_fault;

    always #2 clk = ~clk;

    mem_integrity_mon #(
        .WORDS(WORDS), .CYC_PER_US(CPU), .NVM_PERIOD_US(50), .POR_PERIOD_US(1),
        .EXCL_A(EXA), .EXCL_B(EXB), .ROM_VAL(ROM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .nvm_addr(nvm_addr), .nvm_rdata(nvm_rdata),
        .nvm_ref(nvm_ref), .vol_we(vol_we), .vol_wdata(vol_wdata),
        .vol_rdata(vol_rdata), .nvm_fault(nvm_fault), .por_fault(por_fault)
    );

    assign nvm_rdata = nvm_mem[nvm_addr];
    assign vol_rdata = vol_reg;

    always @(posedge clk) begin
        if (vol_we)   vol_reg <= vol_wdata;
        else if (hit) vol_reg <= vol_reg ^ hit_mask;
    end

    int edges;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    typedef struct {
        logic  v;
        string r;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    logic prev_mis = 1'b0;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at edge %0d", r, act, exp, edges);
        end
    endtask

    function automatic logic [15:0] model_sum();
        logic [15:0] s = '0;
        for (int i = 0; i < WORDS; i++)
            if (i != EXA && i != EXB) s = s + nvm_mem[i];
        return s;
    endfunction

    // monitor: compares outputs with the expected schedule
    always @(negedge clk) begin
        if (rst_n && edges > 0) begin
            int m, k, off;
            exp_t e;
            m = edges - 1;
            k = m / N;
            off = m % N;
            chk("R2", vol_we, 0);
            if (m > 0 && (m % P) == 0)
                chk(prev_mis ? "R5" : "R4", por_fault, prev_mis);
            else
                chk("R3", por_fault, 0);
            prev_mis = (vol_rdata != ROM);
            if (k >= 1 && off < WORDS) chk("R6", nvm_addr, off);
            if (k >= 1 && off == WORDS) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R8 actual=%0b expected=none (no scan queued)", nvm_fault);
                end else begin
                    e = exp_q.pop_front();
                    chk(e.r, nvm_fault, e.v);
                end
            end else if (nvm_fault) begin
                chk("R10", nvm_fault, 0);
            end
        end
    end

    task automatic wait_scan(input int k);
        while (edges < k * N + WORDS + 2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        hit = 1'b0;
        hit_mask = 16'h0100;
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) nvm_mem[i] = 16'h1357 * 16'(i + 1);
        nvm_ref = model_sum();
        exp_q.push_back('{1'b0, "R7"});  // scan 1: matching bank
        repeat (3) @(negedge clk);
        chk("R1", nvm_fault, 0);
        chk("R1", por_fault, 0);
        chk("R1", vol_we, 1);
        chk("R1", vol_wdata, ROM);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", vol_reg, ROM);

        wait_scan(1);
        nvm_mem[5] = nvm_mem[5] ^ 16'h0040;           // R8: flip a counted bit
        exp_q.push_back('{1'b1, "R8"});

        wait_scan(2);
        nvm_mem[5] = nvm_mem[5] ^ 16'h0040;
        nvm_mem[EXA] = 16'hDEAD;                      // R9: excluded words only
        nvm_mem[EXB] = 16'hBEEF;
        exp_q.push_back('{1'b0, "R9"});
        while (edges < 300) @(negedge clk);
        hit = 1'b1;                                    // R5: one-shot upset
        @(negedge clk);
        hit = 1'b0;

        wait_scan(3);
        for (int i = 0; i < WORDS; i++) nvm_mem[i] = 16'hFFFF;
        nvm_ref = 16'hFFF2;                            // R7: 14 x FFFF wraps
        exp_q.push_back('{1'b0, "R7"});

        wait_scan(4);
        nvm_ref = 16'hFFF3;                            // R8: reference off by one
        exp_q.push_back('{1'b1, "R8"});

        wait_scan(5);
        chk("R8", exp_q.size(), 0);
        chk("R5", vol_rdata != ROM, 1);

        rst_n = 1'b0;                                  // R11: power cycle
        repeat (2) @(negedge clk);
        chk("R11", por_fault, 0);
        chk("R11", vol_we, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", vol_rdata, ROM);
        repeat (20) @(negedge clk);
        chk("R11", vol_rdata, ROM);
        finish_run();
    end
endmodule